// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, made of a segment number and an offset, into a physical address. It keeps a small table of segment descriptors. Each descriptor holds a base address, a length limit, a valid flag and three permission flags for read, write and execute. Software fills the table through a plain write port. It also loads a table-length register that sets how many segment numbers are legal.

Each request carries a segment number, an offset and an access type. One cycle after the request is accepted, the block returns a registered response. The response holds either the translated physical address or a fault flag with a cause code, never both. Each check that can fail has its own cause code. The block issues no address for a faulting access, and fault handling is left to the consumer.

Requests use a valid/ready handshake and responses use valid/ready back-pressure. `req_ready` is high when no response is held, or when the held response is taken in the same cycle. While `resp_valid` is high and `resp_ready` is low, the response stays unchanged and no new request is accepted. A write to the table or to the length register takes effect for requests accepted from the next cycle on.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `resp_valid` is 0, `req_ready` is 1, the length register is 0 and every table entry is invalid.
- R2: A request whose segment number is not strictly less than the length register faults with cause 3'b001.
- R3: A request to an entry whose valid flag is 0 faults with cause 3'b010.
- R4: A request whose offset is not strictly less than the entry limit faults with cause 3'b011. A limit of 0 rejects every offset.
- R5: The access type is 2'b00 for read, 2'b01 for write and 2'b10 for execute, and each is checked against the entry's r, w or x flag. Type 2'b11 is never permitted. A refused access faults with cause 3'b100.
- R6: An access that passes every check returns `resp_fault`=0, cause 3'b000 and `resp_addr` = base + offset modulo 2^24.
- R7: When several checks fail, the reported cause follows the priority segment range, then valid, then limit, then permission.
- R8: A request accepted at a clock edge produces `resp_valid` after that edge. While `resp_ready` is low, the response stays stable and `req_ready` is 0.
- R9: A table write (`wr_en`, `wr_idx`, `wr_data`) is seen by requests accepted in later cycles, not by a request accepted at the same edge. The `wr_data` layout is: base in bits [23:0], limit in bits [40:24], r in bit 41, w in bit 42, x in bit 43, valid in bit 44.
- R10: A length write (`len_wr_en`, `len_wr_data`) is seen by requests accepted in later cycles only.
- R11: `resp_fault` is 1 exactly when the cause is nonzero, and `resp_addr` is 0 whenever `resp_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_data | input | 45 | Descriptor: valid, x, w, r, limit, base |
| len_wr_en | input | 1 | Length register write strobe |
| len_wr_data | input | 5 | Number of legal segments (0 to 16) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset within segment |
| req_type | input | 2 | Access type: 0 read, 1 write, 2 execute |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_fault | output | 1 | Access trapped |
| resp_cause | output | 3 | Fault cause, 0 when no fault |
| resp_addr | output | 24 | Physical address, 0 on fault |

## Verification
The assertions check every cycle that a fault never carries an address. They also check that an out-of-range segment number always reports the range cause, that type 3 never succeeds, and that an accepted request always yields a response that holds steady under back-pressure. Only the bench's scenarios can show the actual address arithmetic, including wrap past the top of the address space. The same holds for the full priority order among failing checks, and for the point in time at which table and length writes become visible to requests.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEG_W  = 4;
  localparam int OFF_W  = 16;
  localparam int BASE_W = 24;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'b000,
    CAUSE_RANGE = 3'b001,
    CAUSE_INVAL = 3'b010,
    CAUSE_LIMIT = 3'b011,
    CAUSE_PERM  = 3'b100
  } cause_t;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_BAD   = 2'b11
  } acc_t;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = seg_xlate_pkg::SEG_W,
  parameter int ENT_W = 45,
  parameter int VLD_B = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_data
);
  localparam int DEPTH = 1 << SEG_W;

  logic [ENT_W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (wr_en && (wr_idx == SEG_W'(g))) begin
        ent_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = ent_q[rd_idx];

  // R1: no entry is valid straight after reset
  a_r1_reset_invalid: assert property (@(posedge clk)
    $rose(rst_n) |-> !ent_q[rd_idx][VLD_B]);
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = seg_xlate_pkg::SEG_W,
  parameter int OFF_W  = seg_xlate_pkg::OFF_W,
  parameter int BASE_W = seg_xlate_pkg::BASE_W,
  localparam int LIM_W = OFF_W + 1,
  localparam int LEN_W = SEG_W + 1
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        acc,
  input  logic [LEN_W-1:0]  tbl_len,
  input  logic [BASE_W-1:0] ent_base,
  input  logic [LIM_W-1:0]  ent_limit,
  input  logic              ent_r,
  input  logic              ent_w,
  input  logic              ent_x,
  input  logic              ent_valid,
  output cause_t            cause,
  output logic [BASE_W-1:0] phys
);
  logic perm_ok;

  always_comb begin
    unique case (acc_t'(acc))
      ACC_READ:  perm_ok = ent_r;
      ACC_WRITE: perm_ok = ent_w;
      ACC_EXEC:  perm_ok = ent_x;
      default:   perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if ({1'b0, seg} >= tbl_len)               cause = CAUSE_RANGE;
    else if (!ent_valid)                      cause = CAUSE_INVAL;
    else if ({1'b0, off} >= ent_limit)        cause = CAUSE_LIMIT;
    else if (!perm_ok)                        cause = CAUSE_PERM;
    else                                      cause = CAUSE_NONE;
  end

  assign phys = (cause == CAUSE_NONE) ? (ent_base + BASE_W'(off)) : '0;

  // R5: the reserved access type never passes
  a_r5_bad_type: assert final (!(acc == 2'b11 && cause == CAUSE_NONE));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = seg_xlate_pkg::SEG_W,
  parameter int OFF_W  = seg_xlate_pkg::OFF_W,
  parameter int BASE_W = seg_xlate_pkg::BASE_W,
  localparam int LIM_W = OFF_W + 1,
  localparam int LEN_W = SEG_W + 1,
  localparam int LIM_B = BASE_W,
  localparam int R_B   = LIM_B + LIM_W,
  localparam int W_B   = R_B + 1,
  localparam int X_B   = R_B + 2,
  localparam int VLD_B = R_B + 3,
  localparam int ENT_W = VLD_B + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [ENT_W-1:0]  wr_data,
  input  logic              len_wr_en,
  input  logic [LEN_W-1:0]  len_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_type,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_fault,
  output logic [2:0]        resp_cause,
  output logic [BASE_W-1:0] resp_addr
);
  logic [LEN_W-1:0]  len_q;
  logic [ENT_W-1:0]  ent;
  cause_t            cause_c;
  logic [BASE_W-1:0] phys_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         len_q <= '0;
    else if (len_wr_en) len_q <= len_wr_data;
  end

  seg_table #(.SEG_W(SEG_W), .ENT_W(ENT_W), .VLD_B(VLD_B)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(req_seg), .rd_data(ent)
  );

  seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)) u_check (
    .seg(req_seg), .off(req_off), .acc(req_type), .tbl_len(len_q),
    .ent_base(ent[BASE_W-1:0]), .ent_limit(ent[LIM_B +: LIM_W]),
    .ent_r(ent[R_B]), .ent_w(ent[W_B]), .ent_x(ent[X_B]),
    .ent_valid(ent[VLD_B]),
    .cause(cause_c), .phys(phys_c)
  );

  assign req_ready = !resp_valid || resp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_cause <= 3'b000;
      resp_addr  <= '0;
    end else if (req_ready) begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_fault <= (cause_c != CAUSE_NONE);
        resp_cause <= cause_c;
        resp_addr  <= phys_c;
      end
    end
  end

  // R11: a trapped access never carries an address
  a_r11_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_addr == '0 && resp_cause != 3'b000));

  // R8: an accepted request yields a response on the next cycle
  a_r8_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);

  // R8: a stalled response stays put
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=>
      (resp_valid && $stable(resp_addr) && $stable(resp_cause) && $stable(resp_fault)));

  // R2: out-of-range segment number reports the range cause
  a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ({1'b0, req_seg} >= len_q)) |=> (resp_cause == 3'b001));

  // R5: the reserved access type is always trapped
  a_r5_type3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_type == 2'b11) |=> resp_fault);
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [44:0] wr_data = '0;
  logic        len_wr_en = 1'b0;
  logic [4:0]  len_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  req_type = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic        resp_fault;
  logic [2:0]  resp_cause;
  logic [23:0] resp_addr;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .len_wr_en(len_wr_en), .len_wr_data(len_wr_data),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .req_type(req_type),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_fault(resp_fault), .resp_cause(resp_cause), .resp_addr(resp_addr)
  );

  // seg, off, type, expected cause, expected address
  localparam logic [48:0] VEC [16] = '{
    {4'd0,  16'h0010, 2'd0, 3'd0, 24'h010010},  // R6 read ok
    {4'd0,  16'h00FF, 2'd0, 3'd0, 24'h0100FF},  // R6 last offset
    {4'd0,  16'h0100, 2'd0, 3'd3, 24'h000000},  // R4 offset == limit
    {4'd0,  16'h0010, 2'd1, 3'd4, 24'h000000},  // R5 write to read-only
    {4'd1,  16'h0FFF, 2'd1, 3'd0, 24'h200FFF},  // R6 write ok
    {4'd1,  16'h0000, 2'd2, 3'd4, 24'h000000},  // R5 exec refused
    {4'd2,  16'h0000, 2'd0, 3'd2, 24'h000000},  // R3 invalid entry
    {4'd3,  16'h0200, 2'd2, 3'd0, 24'h000100},  // R6 wrap
    {4'd3,  16'hFFFF, 2'd2, 3'd0, 24'h00FEFF},  // R6 full limit, wrap
    {4'd3,  16'h0000, 2'd0, 3'd4, 24'h000000},  // R5 read on exec-only
    {4'd5,  16'h0000, 2'd0, 3'd3, 24'h000000},  // R4 zero limit
    {4'd4,  16'h0000, 2'd0, 3'd2, 24'h000000},  // R3 never-written entry
    {4'd6,  16'h0000, 2'd0, 3'd1, 24'h000000},  // R2 seg == len
    {4'd15, 16'h0000, 2'd3, 3'd1, 24'h000000},  // R7 range over perm
    {4'd1,  16'h2000, 2'd3, 3'd3, 24'h000000},  // R7 limit over perm
    {4'd0,  16'h0000, 2'd3, 3'd4, 24'h000000}   // R5 type 3
  };

  function automatic logic [44:0] mk(input logic v, input logic x, input logic w,
                                     input logic r, input logic [16:0] lim,
                                     input logic [23:0] base);
    return {v, x, w, r, lim, base};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] idx, input logic [44:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_len(input logic [4:0] n);
    @(negedge clk);
    len_wr_en = 1'b1; len_wr_data = n;
    @(negedge clk);
    len_wr_en = 1'b0;
  endtask

  // drive at a falling edge, accepted at next rising edge, sample at next falling edge
  task automatic xfer(input string tag, input logic [3:0] s, input logic [15:0] o,
                      input logic [1:0] t, input logic [2:0] ec, input logic [23:0] ea);
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_off = o; req_type = t;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 32'(resp_valid), 32'd1);
    chk({tag, " cause"}, 32'(resp_cause), 32'(ec));
    chk({tag, " fault"}, 32'(resp_fault), 32'(ec != 3'd0));
    chk({tag, " addr"},  32'(resp_addr),  32'(ea));
  endtask

  initial begin
    #150000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 resp_valid in reset", 32'(resp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 resp_valid after reset", 32'(resp_valid), 32'd0);
    chk("R1 req_ready after reset", 32'(req_ready), 32'd1);
    xfer("R1 len zero", 4'd0, 16'h0, 2'd0, 3'd1, 24'h0);
    set_len(5'd16);
    xfer("R1 entry invalid", 4'd9, 16'h0, 2'd0, 3'd2, 24'h0);

    load(4'd0, mk(1, 0, 0, 1, 17'h00100, 24'h010000));
    load(4'd1, mk(1, 0, 1, 1, 17'h01000, 24'h200000));
    load(4'd2, mk(0, 1, 1, 1, 17'h00100, 24'h000000));
    load(4'd3, mk(1, 1, 0, 0, 17'h10000, 24'hFFFF00));
    load(4'd5, mk(1, 1, 1, 1, 17'h00000, 24'h000000));
    set_len(5'd6);

    for (int i = 0; i < 16; i++) begin
      xfer($sformatf("vec%0d R2-R7", i), VEC[i][48:45], VEC[i][44:29],
           VEC[i][28:27], VEC[i][26:24], VEC[i][23:0]);
    end

    // R9: write and request at the same edge; request sees old entry
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd4; wr_data = mk(1, 1, 1, 1, 17'h00010, 24'h123400);
    req_valid = 1'b1; req_seg = 4'd4; req_off = 16'h1; req_type = 2'd0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R9 same-edge cause", 32'(resp_cause), 32'd2);
    xfer("R9 next request", 4'd4, 16'h1, 2'd0, 3'd0, 24'h123401);

    // R10: length write at the same edge as a request
    @(negedge clk);
    len_wr_en = 1'b1; len_wr_data = 5'd4;
    req_valid = 1'b1; req_seg = 4'd4; req_off = 16'h2; req_type = 2'd1;
    @(negedge clk);
    len_wr_en = 1'b0; req_valid = 1'b0;
    chk("R10 same-edge addr", 32'(resp_addr), 32'h123402);
    xfer("R10 later request", 4'd4, 16'h2, 2'd1, 3'd1, 24'h0);

    // R8: back-pressure holds the response
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid = 1'b1; req_seg = 4'd1; req_off = 16'h5; req_type = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 stall valid", 32'(resp_valid), 32'd1);
    chk("R8 stall ready", 32'(req_ready), 32'd0);
    chk("R8 stall addr", 32'(resp_addr), 32'h200005);
    @(negedge clk);
    chk("R8 held valid", 32'(resp_valid), 32'd1);
    chk("R8 held addr", 32'(resp_addr), 32'h200005);
    resp_ready = 1'b1;
    req_valid = 1'b1; req_seg = 4'd1; req_off = 16'h6; req_type = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 follow-on addr", 32'(resp_addr), 32'h200006);
    chk("R11 follow-on fault", 32'(resp_fault), 32'd0);
    @(negedge clk);
    chk("R8 drained", 32'(resp_valid), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule